// File: doc/BRIEF.md
# Two-Phase DMA Unit Mover with Bus-Width Conversion

This block carries out a single DMA unit transfer as two separate phases. A start pulse latches a source address, a destination address, the unit size (byte or halfword) and the bus width on each side. The engine first runs read accesses at the source and collects the data in an internal holding register. It then leaves the bus idle for one clock. After that it runs write accesses that put the held data on the destination.

The two bus widths decide how many accesses each phase needs. A halfword unit on an 8-bit side is split into two byte accesses, low byte first. A halfword unit on a 16-bit or 32-bit side uses one 16-bit access. A byte unit always uses single 8-bit accesses. Every access stays on the bus until the slave raises ready. One clock after the last write is accepted, a done pulse appears.

The bus carries data right-aligned. A byte uses bits [7:0] and a halfword uses bits [15:0]. Width codes on `srcWidth` and `dstWidth` are 0 for 8-bit, 1 for 16-bit, and 2 or 3 for 32-bit. `busSize` is 0 for an 8-bit access and 1 for a 16-bit access.

Top module: `dma_twophase_mover`

## Requirements
- R1: While idle, a start pulse latches the addresses, unit size and widths. The first read access is on the bus in the clock after the start edge. Reads present the source address and writes present the destination address.
- R2: Between the accepted last read and the first write there is exactly one clock with `busReq` low.
- R3: A byte unit (`unitHalf`=0) makes exactly one 8-bit read and one 8-bit write, whatever the widths. Only data bits [7:0] are used, and the destination byte at address+1 is left unchanged.
- R4: A halfword unit from an 8-bit source (width code 0) makes two 8-bit reads. The first is at the source address N and fills the low byte. The second is at N+1 and fills the high byte.
- R5: A halfword unit from a 16-bit or 32-bit source makes one 16-bit read. Read data bits [31:16] are ignored.
- R6: A halfword unit to an 8-bit destination makes two 8-bit writes. The low byte goes first to address N and the high byte goes to N+1.
- R7: A halfword unit to a 16-bit or 32-bit destination makes one 16-bit write. Write data bits above the access width are driven to zero on every write.
- R8: An access keeps its address, direction, size and write data stable until `busReady` is seen high at a clock edge, and the engine does not advance before that.
- R9: `doneOut` is high for exactly one clock, in the clock after the final write is accepted, and `busReq` is low while it is high.
- R10: A start pulse that arrives while a transfer is in progress is ignored. The running transfer finishes with its original parameters and gives a single done pulse.
- R11: During and right after reset, `busReq` and `doneOut` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startIn | input | 1 | Start pulse for one unit transfer |
| unitHalf | input | 1 | Unit size: 0 byte, 1 halfword |
| srcWidth | input | 2 | Source bus width code (0:8, 1:16, 2/3:32) |
| dstWidth | input | 2 | Destination bus width code (0:8, 1:16, 2/3:32) |
| srcAddr | input | ADDR_W | Source address of the unit |
| dstAddr | input | ADDR_W | Destination address of the unit |
| busReq | output | 1 | Access request, held until ready |
| busWrite | output | 1 | 1 for write access, 0 for read |
| busSize | output | 1 | Access width: 0 8-bit, 1 16-bit |
| busAddr | output | ADDR_W | Access address |
| busWdata | output | DATA_W | Write data, right-aligned |
| busRdata | input | DATA_W | Read data, right-aligned |
| busReady | input | 1 | Slave accepts the current access at this edge |
| doneOut | output | 1 | One-clock pulse after the final write |

## Verification
The bench runs every pairing of split and unsplit sides with both unit sizes, and adds slave wait states. This shows up a design that drops the idle clock or stretches it while the bus stalls. The memory model puts junk in the read data lanes above the access width. A design that lets those lanes into the holding register would write corrupted bytes, and a design that swaps the byte order on split accesses would store the halfword reversed. A second start pulse in the middle of a transfer catches a design that restarts or takes the new parameters. Counting done pulses catches a pulse that is stretched or that fires after every write.

// File: rtl/dma_tp_pkg.sv
package dma_tp_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_GAP   = 2'd2,
    PH_WRITE = 2'd3
  } phase_e;

  // bus width codes at the configuration inputs
  localparam logic [1:0] WIDTH_8 = 2'd0;

  // access size codes on the bus
  localparam logic SIZE_8  = 1'b0;
  localparam logic SIZE_16 = 1'b1;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // latch addresses
    logic capture;  // take read data into the holding register
    logic beatHi;   // second beat of a split access (address +1, high byte)
    logic wide;     // current access is 16-bit
    logic writePh;  // current access is a write
    logic drive;    // an access is on the bus
  } dpStrobe_t;

endpackage

// File: rtl/dma_tp_ctrl.sv
module dma_tp_ctrl
  import dma_tp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startIn,
  input  logic       unitHalf,
  input  logic [1:0] srcWidth,
  input  logic [1:0] dstWidth,
  input  logic       busReady,
  output logic       busReq,
  output logic       busWrite,
  output logic       busSize,
  output logic       doneOut,
  output dpStrobe_t  strb
);

  phase_e phaseQ;
  logic   beatQ;
  logic   halfQ;
  logic   srcSplitQ;
  logic   dstSplitQ;

  logic inRead;
  logic inWrite;
  logic curSplit;
  logic wideAcc;
  logic lastBeat;
  logic accepted;

  always_comb begin
    inRead   = (phaseQ == PH_READ);
    inWrite  = (phaseQ == PH_WRITE);
    busReq   = inRead | inWrite;
    busWrite = inWrite;
    curSplit = inWrite ? dstSplitQ : srcSplitQ;
    wideAcc  = halfQ & ~curSplit;
    busSize  = wideAcc ? SIZE_16 : SIZE_8;
    lastBeat = ~curSplit | beatQ;
    accepted = busReq & busReady;

    strb.load    = (phaseQ == PH_IDLE) & startIn;
    strb.capture = inRead & busReady;
    strb.beatHi  = beatQ;
    strb.wide    = wideAcc;
    strb.writePh = inWrite;
    strb.drive   = busReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ    <= PH_IDLE;
      beatQ     <= 1'b0;
      halfQ     <= 1'b0;
      srcSplitQ <= 1'b0;
      dstSplitQ <= 1'b0;
      doneOut   <= 1'b0;
    end else begin
      doneOut <= 1'b0;
      unique case (phaseQ)
        PH_IDLE: begin
          if (startIn) begin
            halfQ     <= unitHalf;
            srcSplitQ <= unitHalf & (srcWidth == WIDTH_8);
            dstSplitQ <= unitHalf & (dstWidth == WIDTH_8);
            beatQ     <= 1'b0;
            phaseQ    <= PH_READ;
          end
        end
        PH_GAP: begin
          phaseQ <= PH_WRITE;
        end
        default: begin
          if (accepted) begin
            if (lastBeat) begin
              beatQ   <= 1'b0;
              phaseQ  <= inRead ? PH_GAP : PH_IDLE;
              doneOut <= inWrite;
            end else begin
              beatQ <= 1'b1;
            end
          end
        end
      endcase
    end
  end

  // R2
  idle_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inRead && accepted && lastBeat) |=> (!busReq ##1 (busReq && busWrite)));

  // R8
  hold_ctrl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busReady) |=> (busReq && $stable(busWrite) && $stable(busSize)));

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> !busReq);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && startIn) |=> ($stable(halfQ) && $stable(srcSplitQ) && $stable(dstSplitQ)));

endmodule

// File: rtl/dma_tp_dpath.sv
module dma_tp_dpath
  import dma_tp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [ADDR_W-1:0] srcAddr,
  input  logic [ADDR_W-1:0] dstAddr,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busReady,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata
);

  localparam int HALF_W = 16;
  localparam int BYTE_W = 8;
  localparam int PAD_W  = DATA_W - HALF_W;

  logic [ADDR_W-1:0] srcQ;
  logic [ADDR_W-1:0] dstQ;
  logic [HALF_W-1:0] holdQ;
  logic [ADDR_W-1:0] baseAddr;
  logic [BYTE_W-1:0] beatByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcQ  <= '0;
      dstQ  <= '0;
      holdQ <= '0;
    end else begin
      if (strb.load) begin
        srcQ <= srcAddr;
        dstQ <= dstAddr;
      end
      if (strb.capture) begin
        if (strb.wide)
          holdQ <= busRdata[HALF_W-1:0];
        else if (strb.beatHi)
          holdQ[HALF_W-1:BYTE_W] <= busRdata[BYTE_W-1:0];
        else
          holdQ[BYTE_W-1:0] <= busRdata[BYTE_W-1:0];
      end
    end
  end

  always_comb begin
    baseAddr = strb.writePh ? dstQ : srcQ;
    busAddr  = strb.drive ? (baseAddr + {{(ADDR_W-1){1'b0}}, strb.beatHi}) : '0;
    beatByte = strb.beatHi ? holdQ[HALF_W-1:BYTE_W] : holdQ[BYTE_W-1:0];
    if (!(strb.drive && strb.writePh))
      busWdata = '0;
    else if (strb.wide)
      busWdata = {{PAD_W{1'b0}}, holdQ};
    else
      busWdata = {{(DATA_W-BYTE_W){1'b0}}, beatByte};
  end

  // R8
  hold_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.drive && !busReady) |=> ($stable(busAddr) && $stable(busWdata)));

  // R1
  load_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> !strb.drive);

endmodule

// File: rtl/dma_twophase_mover.sv
module dma_twophase_mover
  import dma_tp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic              unitHalf,
  input  logic [1:0]        srcWidth,
  input  logic [1:0]        dstWidth,
  input  logic [ADDR_W-1:0] srcAddr,
  input  logic [ADDR_W-1:0] dstAddr,
  output logic              busReq,
  output logic              busWrite,
  output logic              busSize,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busReady,
  output logic              doneOut
);

  dpStrobe_t strb;

  dma_tp_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .startIn  (startIn),
    .unitHalf (unitHalf),
    .srcWidth (srcWidth),
    .dstWidth (dstWidth),
    .busReady (busReady),
    .busReq   (busReq),
    .busWrite (busWrite),
    .busSize  (busSize),
    .doneOut  (doneOut),
    .strb     (strb)
  );

  dma_tp_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .srcAddr  (srcAddr),
    .dstAddr  (dstAddr),
    .busRdata (busRdata),
    .busReady (busReady),
    .busAddr  (busAddr),
    .busWdata (busWdata)
  );

endmodule

// File: tb/dma_twophase_mover_tb_top.sv
module dma_twophase_mover_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0;
  logic        unitHalf = 1'b0;
  logic [1:0]  srcWidth = 2'd0;
  logic [1:0]  dstWidth = 2'd0;
  logic [31:0] srcAddr = '0;
  logic [31:0] dstAddr = '0;
  logic        busReq;
  logic        busWrite;
  logic        busSize;
  logic [31:0] busAddr;
  logic [31:0] busWdata;
  logic [31:0] busRdata = '0;
  logic        busReady = 1'b0;
  logic        doneOut;

  always #10 clk = ~clk;

  dma_twophase_mover dut_i (
    .clk(clk), .rstN(rstN), .startIn(startIn), .unitHalf(unitHalf),
    .srcWidth(srcWidth), .dstWidth(dstWidth), .srcAddr(srcAddr), .dstAddr(dstAddr),
    .busReq(busReq), .busWrite(busWrite), .busSize(busSize), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busReady(busReady), .doneOut(doneOut)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  logic [7:0] mem [256];

  // responder / monitor state
  int waitSet = 0;
  int waitCnt = 0;
  int nRd, nWr, rdSz, wrSz, lastRdAcc, lastWrAcc, firstReq, firstWrReq;
  int doneCnt, doneAt, stallBad, upperBad;
  logic [31:0] rdAddrLog [4];
  logic [31:0] wrAddrLog [4];
  logic [31:0] stallAddr, stallData;
  logic        inStall;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clearLog();
    nRd = 0; nWr = 0; rdSz = -1; wrSz = -1; lastRdAcc = -1; lastWrAcc = -1;
    firstReq = -1; firstWrReq = -1; doneCnt = 0; doneAt = -1;
    stallBad = 0; upperBad = 0; inStall = 1'b0;
    for (int i = 0; i < 4; i++) begin rdAddrLog[i] = '0; wrAddrLog[i] = '0; end
  endtask

  // bus slave model with programmable wait states
  initial begin
    clearLog();
    forever begin
      @(negedge clk);
      if (busReady) begin
        busReady = 1'b0;
        waitCnt = 0;
        inStall = 1'b0;
      end
      if (busReq) begin
        if (firstReq < 0) firstReq = cyc;
        if (busWrite && firstWrReq < 0) firstWrReq = cyc;
        if (inStall && (busAddr != stallAddr || busWdata != stallData)) stallBad++;
        if (waitCnt >= waitSet) begin
          busReady = 1'b1;
          if (!busWrite) begin
            if (nRd < 4) rdAddrLog[nRd] = busAddr;
            nRd++; rdSz = int'(busSize); lastRdAcc = cyc;
            if (busSize) busRdata = {16'h5A5A, mem[busAddr[7:0] + 8'd1], mem[busAddr[7:0]]};
            else         busRdata = {24'hC3C3C3, mem[busAddr[7:0]]};
          end else begin
            if (nWr < 4) wrAddrLog[nWr] = busAddr;
            nWr++; wrSz = int'(busSize); lastWrAcc = cyc;
            mem[busAddr[7:0]] = busWdata[7:0];
            if (busSize) begin
              mem[busAddr[7:0] + 8'd1] = busWdata[15:8];
              if (busWdata[31:16] != 0) upperBad++;
            end else if (busWdata[31:8] != 0) upperBad++;
          end
        end else begin
          waitCnt++;
          inStall = 1'b1;
          stallAddr = busAddr;
          stallData = busWdata;
        end
      end
      if (doneOut) begin
        doneCnt++;
        doneAt = cyc;
        if (busReq) stallBad++;
      end
    end
  end

  typedef struct packed {
    logic       half;
    logic [1:0] sw;
    logic [1:0] dw;
    logic [2:0] waits;
    logic [1:0] nr;
    logic [1:0] nw;
    logic       rs;
    logic       ws;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    {1'b1, 2'd0, 2'd1, 3'd0, 2'd2, 2'd1, 1'b0, 1'b1},
    {1'b1, 2'd1, 2'd0, 3'd1, 2'd1, 2'd2, 1'b1, 1'b0},
    {1'b1, 2'd2, 2'd1, 3'd2, 2'd1, 2'd1, 1'b1, 1'b1},
    {1'b1, 2'd1, 2'd2, 3'd0, 2'd1, 2'd1, 1'b1, 1'b1},
    {1'b1, 2'd0, 2'd0, 3'd3, 2'd2, 2'd2, 1'b0, 1'b0},
    {1'b0, 2'd2, 2'd2, 3'd0, 2'd1, 2'd1, 1'b0, 1'b0},
    {1'b0, 2'd1, 2'd0, 3'd1, 2'd1, 2'd1, 1'b0, 1'b0},
    {1'b1, 2'd3, 2'd0, 3'd0, 2'd1, 2'd2, 1'b1, 1'b0}
  };

  int startCyc;

  task automatic launch(input logic h, input logic [1:0] sw, input logic [1:0] dw,
                        input int w, input logic [31:0] s, input logic [31:0] d);
    clearLog();
    waitSet = w;
    mem[d[7:0]] = 8'hA5;
    mem[d[7:0] + 8'd1] = 8'hA5;
    @(negedge clk);
    startIn = 1'b1; unitHalf = h; srcWidth = sw; dstWidth = dw; srcAddr = s; dstAddr = d;
    startCyc = cyc;
    @(negedge clk);
    startIn = 1'b0;
  endtask

  task automatic waitDone();
    int n = 0;
    while (doneCnt == 0 && n < 300) begin @(negedge clk); n++; end
    check(doneCnt != 0, "R9 watchdog", n, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 2));

    // R11: reset state
    repeat (3) @(negedge clk);
    check(busReq == 0 && doneOut == 0, "R11 in reset", int'({busReq, doneOut}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(busReq == 0 && doneOut == 0, "R11 after reset", int'({busReq, doneOut}), 0);

    for (int k = 0; k < NVEC; k++) begin
      logic [31:0] s, d;
      vec_t v;
      v = VECS[k];
      s = 32'h0000_1010 + 32'(8 * k);
      d = 32'h0000_1080 + 32'(8 * k);
      launch(v.half, v.sw, v.dw, int'(v.waits), s, d);
      waitDone();
      // R1 R4 R5 R6 R3: access counts, sizes
      check(nRd == int'(v.nr), "R4 R5 R3 read count", nRd, int'(v.nr));
      check(nWr == int'(v.nw), "R6 R7 R3 write count", nWr, int'(v.nw));
      check(rdSz == int'(v.rs) && wrSz == int'(v.ws), "R5 R7 access sizes",
            rdSz * 2 + wrSz, int'(v.rs) * 2 + int'(v.ws));
      // R1 address order and first access timing
      check(rdAddrLog[0] == s && wrAddrLog[0] == d && (nRd < 2 || rdAddrLog[1] == s + 1)
            && (nWr < 2 || wrAddrLog[1] == d + 1), "R1 R4 R6 addresses",
            int'(wrAddrLog[nWr > 1 ? 1 : 0]), int'(d) + nWr - 1);
      check(firstReq == startCyc + 1, "R1 first access timing", firstReq - startCyc, 1);
      // R2 single idle clock
      check(firstWrReq - lastRdAcc == 2, "R2 idle gap", firstWrReq - lastRdAcc, 2);
      // R9 done pulse
      check(doneCnt == 1 && doneAt == lastWrAcc + 1, "R9 done pulse", doneCnt * 100 + doneAt - lastWrAcc, 101);
      // R8 R7 stability and clean upper lanes
      check(stallBad == 0 && upperBad == 0, "R8 R7 hold and zero upper lanes", stallBad + upperBad, 0);
      // data moved (R5 upper read lanes ignored, R3 neighbour untouched)
      check(mem[d[7:0]] == mem[s[7:0]], "R4 R5 low byte", int'(mem[d[7:0]]), int'(mem[s[7:0]]));
      if (v.half)
        check(mem[d[7:0] + 8'd1] == mem[s[7:0] + 8'd1], "R4 R6 high byte",
              int'(mem[d[7:0] + 8'd1]), int'(mem[s[7:0] + 8'd1]));
      else
        check(mem[d[7:0] + 8'd1] == 8'hA5, "R3 neighbour unchanged", int'(mem[d[7:0] + 8'd1]), 165);
    end

    // R10: start while busy is ignored
    launch(1'b1, 2'd0, 2'd0, 2, 32'h0000_1060, 32'h0000_10E0);
    mem[8'hF0] = 8'h77;
    repeat (3) @(negedge clk);
    startIn = 1'b1; unitHalf = 1'b0; srcWidth = 2'd2; dstWidth = 2'd2;
    srcAddr = 32'h0000_1000; dstAddr = 32'h0000_10F0;
    @(negedge clk);
    startIn = 1'b0;
    waitDone();
    check(nRd == 2 && nWr == 2, "R10 counts unchanged", nRd * 10 + nWr, 22);
    check(doneCnt == 1, "R10 single done", doneCnt, 1);
    check(mem[8'hE0] == mem[8'h60] && mem[8'hE1] == mem[8'h61], "R10 data from first start",
          int'(mem[8'hE0]), int'(mem[8'h60]));
    check(mem[8'hF0] == 8'h77 && wrAddrLog[0] == 32'h0000_10E0, "R10 second target untouched",
          int'(mem[8'hF0]), 119);

    // R11: reset mid-transfer returns to quiet bus
    launch(1'b1, 2'd1, 2'd1, 5, 32'h0000_1030, 32'h0000_10B0);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(busReq == 0 && doneOut == 0, "R11 reset mid-transfer", int'({busReq, doneOut}), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(busReq == 0, "R11 idle after reset", int'(busReq), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule